// File: doc/BRIEF.md
# Host Bus Bridge Controller

The bridge sits between a fast host processor's memory-mapped I/O cycles and a slower clock domain that holds a bus-terminal device and its shared SRAM. The host's select, output-enable, read and write strobes arrive without any timing relation to the slow clock. Each strobe passes through a two-flop synchroniser. A host cycle starts on the synchronised falling edge of the select. At that edge the bridge latches the host address and write data, so the command can finish over several slow clocks.

The two top address bits choose the target: the device registers, the shared memory, a small bank of startup configuration words, or a clear action for the status block. Device and memory cycles run only while the external bus ownership is acknowledged. They then step through setup, a two-clock chip-select strobe and a hold, with a busy flag covering the whole sequence. Configuration accesses and the clear action finish inside the bridge without any external chip select.

Read results leave through a valid/ready pair. `rd_valid` rises in the completion state and stays high, with `rd_data` stable, until the consumer raises `rd_ready`. While it waits, the bridge accepts no new host cycle. Only read commands to device, memory or configuration targets produce a transfer.

Top module: `bus_bridge_ctrl`

## Requirements
- R1: After reset, `task_stat` is 0 (idle), `busy`, `dev_doe`, `clr_stat` and `rd_valid` are 0, `dev_cs_n` and `dev_rw_n` are 1, and every configuration word on `cfg_out` is zero.
- R2: A cycle starts only on the synchronised high-to-low transition of `host_sel_n` while idle. Keeping the select low after a cycle completes starts no further cycle.
- R3: Address bits [AW-1:AW-2] select the target: 0 device registers, 1 shared memory, 2 configuration word number `host_addr[1:0]`, 3 status clear. During a chip-select `tgt_sel` carries these bits and `ext_addr` carries `host_addr[AW-3:0]`.
- R4: A device or memory cycle waits in the decode state (`task_stat` = 1, no chip select) for as long as `bus_ack_n` is high or `bus_in_use` is low.
- R5: A device or memory cycle holds `dev_cs_n` low for exactly two consecutive slow clocks, with address, target and direction stable.
- R6: The state codes are idle 0, decode 1, setup 2, strobe 3, hold 4, done 5. `busy` is high in every state except idle, which gives five busy clocks for an unstalled, unthrottled device access.
- R7: A write (`host_wr_n` low) drives `dev_rw_n` low and `dev_doe` high from setup through hold, with `ext_wdata` equal to the latched host data.
- R8: A read (`host_rd` high with `host_oe_n` low) keeps `dev_rw_n` high and `dev_doe` low. It captures `ext_rdata` on the last chip-select clock and presents it in done. `rd_valid` and `rd_data` hold until `rd_ready` is sampled high.
- R9: A configuration write updates its word in one slow clock (decode straight to done) and never asserts `dev_cs_n`. A configuration read returns the addressed word.
- R10: A clear access pulses `clr_stat` for exactly one clock, asserts no chip select, and leaves the configuration words unchanged.
- R11: A select with neither a write nor a read command goes back to idle without a chip select or a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_n | input | 1 | Host I/O select, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | AW | Host address, held stable during the select |
| host_wdata | input | DW | Host write data, held stable during the select |
| bus_ack_n | input | 1 | External bus ownership acknowledged, active low |
| bus_in_use | input | 1 | Shared bus operation in progress |
| ext_rdata | input | DW | Read data from device or memory |
| rd_ready | input | 1 | Consumer accepts read data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read result |
| busy | output | 1 | Cycle in progress |
| task_stat | output | 3 | Current state code |
| dev_cs_n | output | 1 | Chip select to device and memory, active low |
| dev_rw_n | output | 1 | 1 read, 0 write |
| dev_doe | output | 1 | Write data output enable |
| tgt_sel | output | 2 | Latched target bits |
| ext_addr | output | AW-2 | Latched offset address |
| ext_wdata | output | DW | Latched write data |
| clr_stat | output | 1 | One-clock clear pulse to the status block |
| cfg_out | output | NW*DW | Configuration words, word 0 in the low bits |

## Verification
The bench withholds bus ownership and then drops the bus-in-use flag. A bridge that ignores the gate would strobe chip select onto a bus it does not own. It holds `rd_ready` low through a completed read, where a faulty bridge would lose the word or change it. It counts chip-select clocks, decode clocks and clear pulses per access. This catches a strobe that is one clock short or long, a configuration write that takes a detour, or a clear that also touches the configuration words. A select left low after completion and a select that carries no command check that neither one starts a spurious cycle.

// File: rtl/bbc_pkg.sv
package bbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4,
    ST_DONE   = 3'd5
  } bbc_state_e;

  typedef enum logic [1:0] {
    TGT_DEV = 2'd0,
    TGT_MEM = 2'd1,
    TGT_CFG = 2'd2,
    TGT_CLR = 2'd3
  } bbc_tgt_e;
endpackage

// File: rtl/bbc_sync.sv
module bbc_sync #(
  parameter int         W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        out_q  <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        out_q  <= meta_q;
      end
    end
    assign q[i] = out_q;
  end
endmodule

// File: rtl/bbc_cfg_regs.sv
module bbc_cfg_regs #(
  parameter int DW = 16,
  parameter int NW = 4,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [IW-1:0]  idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic [NW*DW-1:0] words
);
  logic [DW-1:0] word_q [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               word_q[w] <= '0;
      else if (we && (idx == IW'(w)))           word_q[w] <= wdata;
    end
    assign words[w*DW +: DW] = word_q[w];
  end

  assign rdata = word_q[idx];
endmodule

// File: rtl/bbc_seq.sv
module bbc_seq
  import bbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  bbc_tgt_e   tgt,
  input  logic       is_wr,
  input  logic       is_rd,
  input  logic       bus_ok,
  input  logic       rd_ready,
  output bbc_state_e state,
  output logic       latch_en,
  output logic       cfg_we,
  output logic       cap_cfg,
  output logic       cap_ext,
  output logic       clr,
  output logic       cs_n,
  output logic       rw_n,
  output logic       doe,
  output logic       rd_valid
);
  bbc_state_e state_q, state_d;
  logic       has_cmd, local_tgt, want_data, in_xfer;

  assign has_cmd   = is_wr | is_rd;
  assign local_tgt = (tgt == TGT_CFG) || (tgt == TGT_CLR);
  assign want_data = is_rd && !is_wr && (tgt != TGT_CLR);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_DECODE;
      ST_DECODE: begin
        if (!has_cmd)      state_d = ST_IDLE;
        else if (local_tgt) state_d = ST_DONE;
        else if (bus_ok)   state_d = ST_SETUP;
      end
      ST_SETUP:  state_d = ST_STROBE;
      ST_STROBE: state_d = ST_HOLD;
      ST_HOLD:   state_d = ST_DONE;
      ST_DONE:   if (!want_data || rd_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign in_xfer  = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
  assign state    = state_q;
  assign latch_en = (state_q == ST_IDLE) && start;
  assign cfg_we   = (state_q == ST_DECODE) && (tgt == TGT_CFG) && is_wr;
  assign cap_cfg  = (state_q == ST_DECODE) && (tgt == TGT_CFG) && want_data;
  assign cap_ext  = (state_q == ST_HOLD) && want_data;
  assign clr      = (state_q == ST_DECODE) && (tgt == TGT_CLR) && has_cmd;
  assign cs_n     = !((state_q == ST_STROBE) || (state_q == ST_HOLD));
  assign rw_n     = !(in_xfer && is_wr);
  assign doe      = in_xfer && is_wr;
  assign rd_valid = (state_q == ST_DONE) && want_data;
endmodule

// File: rtl/bus_bridge_ctrl.sv
module bus_bridge_ctrl
  import bbc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel_n,
  input  logic             host_oe_n,
  input  logic             host_rd,
  input  logic             host_wr_n,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             bus_ack_n,
  input  logic             bus_in_use,
  input  logic [DW-1:0]    ext_rdata,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic [2:0]       task_stat,
  output logic             dev_cs_n,
  output logic             dev_rw_n,
  output logic             dev_doe,
  output logic [1:0]       tgt_sel,
  output logic [AW-3:0]    ext_addr,
  output logic [DW-1:0]    ext_wdata,
  output logic             clr_stat,
  output logic [NW*DW-1:0] cfg_out
);
  localparam int EAW = AW - 2;
  localparam int IW  = (NW > 1) ? $clog2(NW) : 1;

  // synchronised strobes: {sel_n, oe_n, rd, wr_n}, idle levels 1,1,0,1
  logic [3:0] strb_s;
  logic       sel_prev_q, start;
  logic       sel_s, oe_s, rd_s, wr_s;

  bbc_sync #(.W(4), .RST_VAL(4'b1101)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({host_sel_n, host_oe_n, host_rd, host_wr_n}),
    .q     (strb_s)
  );
  assign {sel_s, oe_s, rd_s, wr_s} = strb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev_q <= 1'b1;
    else        sel_prev_q <= sel_s;
  end
  assign start = sel_prev_q && !sel_s;

  // command latches
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          is_wr_q, is_rd_q, latch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      is_wr_q <= 1'b0;
      is_rd_q <= 1'b0;
    end else if (latch_en) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      is_wr_q <= !wr_s;
      is_rd_q <= rd_s && !oe_s;
    end
  end

  bbc_tgt_e   tgt;
  bbc_state_e state;
  logic       cfg_we, cap_cfg, cap_ext;
  logic [DW-1:0] cfg_rdata;

  assign tgt = bbc_tgt_e'(addr_q[AW-1 -: 2]);

  bbc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tgt      (tgt),
    .is_wr    (is_wr_q),
    .is_rd    (is_rd_q),
    .bus_ok   (!bus_ack_n && bus_in_use),
    .rd_ready (rd_ready),
    .state    (state),
    .latch_en (latch_en),
    .cfg_we   (cfg_we),
    .cap_cfg  (cap_cfg),
    .cap_ext  (cap_ext),
    .clr      (clr_stat),
    .cs_n     (dev_cs_n),
    .rw_n     (dev_rw_n),
    .doe      (dev_doe),
    .rd_valid (rd_valid)
  );

  bbc_cfg_regs #(.DW(DW), .NW(NW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .idx   (addr_q[IW-1:0]),
    .wdata (wdata_q),
    .rdata (cfg_rdata),
    .words (cfg_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (cap_cfg) rdata_q <= cfg_rdata;
    else if (cap_ext) rdata_q <= ext_rdata;
  end

  assign rd_data   = rdata_q;
  assign busy      = (state != ST_IDLE);
  assign task_stat = state;
  assign tgt_sel   = addr_q[AW-1 -: 2];
  assign ext_addr  = addr_q[EAW-1:0];
  assign ext_wdata = wdata_q;
endmodule

// File: rtl/bbc_chk.sv
module bbc_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_cs_n,
  input logic          dev_rw_n,
  input logic          dev_doe,
  input logic          busy,
  input logic          clr_stat,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          bus_ack_n,
  input logic          bus_in_use
);
  AST_CS_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_cs_n) |=> !dev_cs_n);                                  // R5
  AST_CS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_cs_n && $past(!dev_cs_n)) |=> dev_cs_n);                    // R5
  AST_CS_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_cs_n) |-> $past(!bus_ack_n && bus_in_use, 2));          // R4
  AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_cs_n |-> busy);                                              // R6
  AST_DOE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_doe |-> !dev_rw_n);                                           // R7
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> !clr_stat);                                          // R10
  AST_CLR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |-> dev_cs_n);                                           // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));      // R8
endmodule

bind bus_bridge_ctrl bbc_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_cs_n   (dev_cs_n),
  .dev_rw_n   (dev_rw_n),
  .dev_doe    (dev_doe),
  .busy       (busy),
  .clr_stat   (clr_stat),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .bus_ack_n  (bus_ack_n),
  .bus_in_use (bus_in_use)
);

// File: tb/bus_bridge_ctrl_tb.sv
module bus_bridge_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_n = 1'b1, host_oe_n = 1'b1, host_rd = 1'b0, host_wr_n = 1'b1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic bus_ack_n = 1'b0, bus_in_use = 1'b1, rd_ready = 1'b1;
  logic [DW-1:0] ext_rdata;
  logic rd_valid, busy, dev_cs_n, dev_rw_n, dev_doe, clr_stat;
  logic [DW-1:0] rd_data, ext_wdata;
  logic [2:0] task_stat;
  logic [1:0] tgt_sel;
  logic [AW-3:0] ext_addr;
  logic [NW*DW-1:0] cfg_out;

  always #5 clk = ~clk;

  bus_bridge_ctrl #(.DW(DW), .AW(AW), .NW(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_oe_n(host_oe_n),
    .host_rd(host_rd), .host_wr_n(host_wr_n), .host_addr(host_addr),
    .host_wdata(host_wdata), .bus_ack_n(bus_ack_n), .bus_in_use(bus_in_use),
    .ext_rdata(ext_rdata), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .task_stat(task_stat), .dev_cs_n(dev_cs_n),
    .dev_rw_n(dev_rw_n), .dev_doe(dev_doe), .tgt_sel(tgt_sel),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .clr_stat(clr_stat),
    .cfg_out(cfg_out)
  );

  // device and shared memory model
  logic [DW-1:0] dev_mem [64];
  logic [DW-1:0] sh_mem  [64];
  initial begin
    for (int i = 0; i < 64; i++) begin
      dev_mem[i] = 16'hD000 + 16'(i);
      sh_mem[i]  = 16'h5000 + 16'(3 * i);
    end
  end
  assign ext_rdata = (tgt_sel == 2'd0) ? dev_mem[ext_addr] : sh_mem[ext_addr];
  always @(posedge clk) begin
    if (!dev_cs_n && !dev_rw_n) begin
      if (tgt_sel == 2'd0) dev_mem[ext_addr] <= ext_wdata;
      else                 sh_mem[ext_addr]  <= ext_wdata;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard and monitor
  logic [DW-1:0] exp_q [$];
  int cs_tot = 0, clr_tot = 0, valid_tot = 0, dec_tot = 0, busy_tot = 0;
  logic [1:0] exp_tgt;
  logic [5:0] exp_off;
  logic exp_wr;
  logic [DW-1:0] exp_wd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_tot++;
      if (task_stat == 3'd1) dec_tot++;
      if (clr_stat) clr_tot++;
      if (!dev_cs_n) begin
        cs_tot++;
        check("R3 target during chip select", 64'(tgt_sel), 64'(exp_tgt));
        check("R3 offset during chip select", 64'(ext_addr), 64'(exp_off));
        check("R5 direction during chip select", 64'(dev_rw_n), 64'(!exp_wr));
        check("R7 output enable during chip select", 64'(dev_doe), 64'(exp_wr));
        if (exp_wr) check("R7 write data", 64'(ext_wdata), 64'(exp_wd));
      end
      if (rd_valid && rd_ready) begin
        valid_tot++;
        if (exp_q.size() == 0) check("R8 unexpected read transfer", 64'(rd_data), 64'hFFFF_FFFF);
        else check("R8 read data", 64'(rd_data), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic wait_busy(input logic lvl, input string tag);
    for (int i = 0; i < 300; i++) begin
      if (busy === lvl) return;
      @(negedge clk);
    end
    check(tag, 64'(busy), 64'(lvl));
  endtask

  task automatic release_host();
    @(negedge clk);
    host_sel_n = 1'b1; host_rd = 1'b0; host_oe_n = 1'b1; host_wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // kind: 0 read, 1 write, 2 no command
  task automatic start_access(input logic [1:0] tgt, input logic [5:0] off,
                              input int kind, input logic [DW-1:0] wd);
    @(negedge clk);
    exp_tgt = tgt; exp_off = off; exp_wr = (kind == 1); exp_wd = wd;
    host_addr = {tgt, off}; host_wdata = wd;
    host_rd = (kind == 0); host_oe_n = (kind != 0); host_wr_n = (kind != 1);
    host_sel_n = 1'b0;
    @(negedge clk);
    wait_busy(1'b1, "R2 cycle start timeout");
  endtask

  task automatic access(input logic [1:0] tgt, input logic [5:0] off,
                        input int kind, input logic [DW-1:0] wd, input bit keep_sel);
    start_access(tgt, off, kind, wd);
    wait_busy(1'b0, "R6 cycle end timeout");
    if (!keep_sel) release_host();
  endtask

  int cs0, clr0, v0, d0, b0;
  task automatic snap();
    cs0 = cs_tot; clr0 = clr_tot; v0 = valid_tot; d0 = dec_tot; b0 = busy_tot;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state code", 64'(task_stat), 64'd0);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 chip select", 64'(dev_cs_n), 64'd1);
    check("R1 read/write", 64'(dev_rw_n), 64'd1);
    check("R1 output enable", 64'(dev_doe), 64'd0);
    check("R1 clear", 64'(clr_stat), 64'd0);
    check("R1 read valid", 64'(rd_valid), 64'd0);
    check("R1 config words", 64'(cfg_out), 64'd0);

    // R9 config write: one decode clock, no chip select
    snap();
    access(2'd2, 6'd1, 1, 16'hA5A5, 0);
    check("R9 config word 1", 64'(cfg_out[1*DW +: DW]), 64'hA5A5);
    check("R9 no chip select", 64'(cs_tot - cs0), 64'd0);
    check("R9 single decode clock", 64'(dec_tot - d0), 64'd1);
    access(2'd2, 6'd3, 1, 16'h1234, 0);
    check("R9 config word 3", 64'(cfg_out[3*DW +: DW]), 64'h1234);
    check("R9 config word 0 untouched", 64'(cfg_out[0 +: DW]), 64'h0);
    exp_q.push_back(16'hA5A5);
    snap();
    access(2'd2, 6'd1, 0, 16'h0, 0);
    check("R9 config read transfer", 64'(valid_tot - v0), 64'd1);

    // R5 R6 R8 device read
    snap();
    exp_q.push_back(16'hD005);
    access(2'd0, 6'd5, 0, 16'h0, 0);
    check("R5 chip select clocks", 64'(cs_tot - cs0), 64'd2);
    check("R6 busy clocks", 64'(busy_tot - b0), 64'd5);
    check("R8 device read transfer", 64'(valid_tot - v0), 64'd1);

    // R7 memory write then reads, R3 target separation
    snap();
    access(2'd1, 6'd9, 1, 16'hBEEF, 0);
    check("R7 write chip select clocks", 64'(cs_tot - cs0), 64'd2);
    check("R7 no read transfer on write", 64'(valid_tot - v0), 64'd0);
    exp_q.push_back(16'hBEEF);
    access(2'd1, 6'd9, 0, 16'h0, 0);
    exp_q.push_back(16'hD009);
    access(2'd0, 6'd9, 0, 16'h0, 0);

    // R10 clear action
    snap();
    access(2'd3, 6'd0, 1, 16'h7777, 0);
    check("R10 clear pulses", 64'(clr_tot - clr0), 64'd1);
    check("R10 no chip select", 64'(cs_tot - cs0), 64'd0);
    check("R10 config word 1 kept", 64'(cfg_out[1*DW +: DW]), 64'hA5A5);
    check("R10 config word 3 kept", 64'(cfg_out[3*DW +: DW]), 64'h1234);

    // R11 select without command
    snap();
    access(2'd0, 6'd4, 2, 16'h0, 0);
    check("R11 no chip select", 64'(cs_tot - cs0), 64'd0);
    check("R11 no read transfer", 64'(valid_tot - v0), 64'd0);
    check("R11 back to idle", 64'(task_stat), 64'd0);

    // R4 bus ownership not acknowledged
    snap();
    bus_ack_n = 1'b1;
    start_access(2'd1, 6'd2, 1, 16'h4242);
    repeat (10) @(negedge clk);
    check("R4 waits in decode", 64'(task_stat), 64'd1);
    check("R4 no chip select without ack", 64'(cs_tot - cs0), 64'd0);
    bus_ack_n = 1'b0; bus_in_use = 1'b0;
    repeat (6) @(negedge clk);
    check("R4 waits without bus in use", 64'(task_stat), 64'd1);
    check("R4 no chip select without bus in use", 64'(cs_tot - cs0), 64'd0);
    bus_in_use = 1'b1;
    wait_busy(1'b0, "R4 completion timeout");
    release_host();
    check("R4 chip select after grant", 64'(cs_tot - cs0), 64'd2);
    exp_q.push_back(16'h4242);
    access(2'd1, 6'd2, 0, 16'h0, 0);

    // R8 back-pressure
    rd_ready = 1'b0;
    exp_q.push_back(16'hD002);
    start_access(2'd0, 6'd2, 0, 16'h0);
    for (int i = 0; i < 50 && !rd_valid; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 valid held", 64'(rd_valid), 64'd1);
    check("R8 waits in done", 64'(task_stat), 64'd5);
    check("R8 data held", 64'(rd_data), 64'hD002);
    rd_ready = 1'b1;
    wait_busy(1'b0, "R8 release timeout");
    release_host();

    // R2 select held low after completion
    exp_q.push_back(16'hD007);
    access(2'd0, 6'd7, 0, 16'h0, 1);
    snap();
    repeat (12) @(negedge clk);
    check("R2 no restart while select held", 64'(busy_tot - b0), 64'd0);
    check("R2 no chip select while select held", 64'(cs_tot - cs0), 64'd0);
    release_host();

    check("R8 scoreboard drained", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule